// File: doc/BRIEF.md
# Bus Clock Run Request Controller

This block sits on the device side of a shared, active-low clock-run wire. The host pulls the wire low while the bus clock is running or about to start, and lets it rise when it wants to stop the clock. The device may also pull the wire low, but never drives it high. It does so for three reasons: to keep the host from halting the clock while traffic is pending, to ask for a halted clock to be restarted, or to hold the clock permanently when the clock-run feature is switched off. Switching the feature off is the fallback for systems whose wake-up latency is too long, since a long latency would overrun the receive path.

The block runs on a free-running local clock. It samples the wire through a configurable synchroniser, and it takes a pending-traffic flag, an enable bit and a bus-clock-halted flag. It produces an open-drain pull-low enable for the wire and a flag that tells whether the device is currently holding the clock. A restart request stays active until the wire is seen asserted with the clock running for a configurable number of consecutive cycles. It then either turns into a hold or is released.

Top module: `clkrun_req_ctrl`

## Requirements
- R1: While `rst_n` is low, `line_drive_low` and `clk_claimed` are both 0.
- R2: With the feature enabled and no pending traffic, a released wire stays released (`line_drive_low` stays 0), whatever level the wire has.
- R3: With traffic pending, the feature enabled and the clock running, a high (deasserted) wire causes `line_drive_low` and `clk_claimed` to rise SYNC_STAGES+1 cycles after the wire rises.
- R4: With traffic pending and the clock running, the device does not drive while the synchronised wire is low (asserted by the host).
- R5: While holding the clock with the feature enabled, the hold ends and the wire is released one cycle after pending traffic clears.
- R6: Pending traffic while the bus clock is halted, with the feature enabled, produces a restart request on the next cycle: `line_drive_low`=1 and `clk_claimed`=0.
- R7: A restart request is held until the synchronised wire is low and the clock is running for CONFIRM_CYCLES consecutive cycles. A halted cycle restarts the count, and clearing pending traffic does not end the request early.
- R8: When the restart is confirmed, the block moves to a hold (`clk_claimed`=1) if traffic is still pending, and otherwise releases the wire, on the cycle of the last confirming sample.
- R9: With the feature disabled, `line_drive_low` and `clk_claimed` are 1 from the next cycle on, regardless of traffic, wire level or clock state.
- R10: On re-enable, the block keeps holding if traffic is pending and the clock runs, requests a restart if traffic is pending and the clock is halted, and otherwise releases.
- R11: `clk_claimed` is never 1 while `line_drive_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_n_i | input | 1 | Sampled level of the shared clock-run wire (0 = asserted) |
| traffic_pending | input | 1 | Device has traffic in flight or queued |
| run_ctl_en | input | 1 | Clock-run feature enable; 0 claims the clock permanently |
| bus_clk_halted | input | 1 | Bus clock is currently stopped |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| clk_claimed | output | 1 | Device is holding the bus clock running |

## Verification
The bench uses the defaults SYNC_STAGES=2 and CONFIRM_CYCLES=2. The two synchroniser stages make the three-cycle claim delay after a host stop request visible and checkable cycle by cycle. A confirmation window of two lets the bench break a confirmation run after its first good cycle, show that the count starts again, and then let the run finish with traffic both present and cleared.

// File: rtl/clkrun_pkg.sv
package clkrun_pkg;
   typedef enum logic [1:0] {
      CR_IDLE    = 2'd0,
      CR_HOLD    = 2'd1,
      CR_RESTART = 2'd2,
      CR_PINNED  = 2'd3
   } cr_state_t;
endpackage

// File: rtl/clkrun_line_sync.sv
module clkrun_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else if (STAGES == 1) chain_q <= d_i;
            else chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/clkrun_confirm.sv
module clkrun_confirm #(
   parameter int CONFIRM_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic good_i,
   output logic done_o
);
   localparam int CNT_W = (CONFIRM_CYCLES > 1) ? $clog2(CONFIRM_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONFIRM_CYCLES - 1);

   logic [CNT_W-1:0] run_q;
   logic             at_last;

   assign at_last = (run_q == LAST);
   assign done_o  = arm_i & good_i & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  run_q <= '0;
      else if (!arm_i || !good_i)  run_q <= '0;
      else if (at_last)            run_q <= '0;
      else                         run_q <= run_q + 1'b1;
   end
endmodule

// File: rtl/clkrun_fsm.sv
module clkrun_fsm
   import clkrun_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_asserted_i,
   input  logic traffic_i,
   input  logic enable_i,
   input  logic halted_i,
   input  logic confirm_done_i,
   output logic restart_o,
   output logic drive_o,
   output logic claim_o
);
   cr_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!enable_i) begin
         state_d = CR_PINNED;
      end else begin
         unique case (state_q)
            CR_IDLE: begin
               if (traffic_i && halted_i)                state_d = CR_RESTART;
               else if (traffic_i && !line_asserted_i)   state_d = CR_HOLD;
            end
            CR_HOLD: begin
               if (!traffic_i)                           state_d = CR_IDLE;
               else if (halted_i)                        state_d = CR_RESTART;
            end
            CR_RESTART: begin
               if (confirm_done_i) state_d = traffic_i ? CR_HOLD : CR_IDLE;
            end
            CR_PINNED: begin
               if (!traffic_i)      state_d = CR_IDLE;
               else if (halted_i)   state_d = CR_RESTART;
               else                 state_d = CR_HOLD;
            end
            default: state_d = CR_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= CR_IDLE;
      else        state_q <= state_d;
   end

   assign restart_o = (state_q == CR_RESTART);
   assign drive_o   = (state_q != CR_IDLE);
   assign claim_o   = (state_q == CR_HOLD) || (state_q == CR_PINNED);
endmodule

// File: rtl/clkrun_req_ctrl.sv
module clkrun_req_ctrl #(
   parameter int SYNC_STAGES    = 2,
   parameter int CONFIRM_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n_i,
   input  logic traffic_pending,
   input  logic run_ctl_en,
   input  logic bus_clk_halted,
   output logic line_drive_low,
   output logic clk_claimed
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (CONFIRM_CYCLES < 1 || CONFIRM_CYCLES > 64) begin : g_bad_conf
         $error("CONFIRM_CYCLES must lie in 1..64");
      end
   endgenerate

   logic line_n_s;
   logic in_restart;
   logic confirm_done;
   logic confirm_good;

   clkrun_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_n_i),
      .q_o   (line_n_s)
   );

   assign confirm_good = !line_n_s && !bus_clk_halted;

   clkrun_confirm #(.CONFIRM_CYCLES(CONFIRM_CYCLES)) u_confirm (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (in_restart),
      .good_i (confirm_good),
      .done_o (confirm_done)
   );

   clkrun_fsm u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .line_asserted_i (!line_n_s),
      .traffic_i       (traffic_pending),
      .enable_i        (run_ctl_en),
      .halted_i        (bus_clk_halted),
      .confirm_done_i  (confirm_done),
      .restart_o       (in_restart),
      .drive_o         (line_drive_low),
      .claim_o         (clk_claimed)
   );
endmodule

// File: rtl/clkrun_req_chk.sv
module clkrun_req_chk (
   input logic clk,
   input logic rst_n,
   input logic traffic_pending,
   input logic run_ctl_en,
   input logic bus_clk_halted,
   input logic line_drive_low,
   input logic clk_claimed
);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ctl_en && !traffic_pending && !line_drive_low) |=> !line_drive_low);

   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_claimed && run_ctl_en && !traffic_pending) |=> !line_drive_low);

   p_restart_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ctl_en && traffic_pending && bus_clk_halted) |=> line_drive_low);

   p_restart_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_drive_low && !clk_claimed && bus_clk_halted) |=> line_drive_low);

   p_pinned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_ctl_en |=> (line_drive_low && clk_claimed));

   p_claim_drives_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clk_claimed |-> line_drive_low);
endmodule

bind clkrun_req_ctrl clkrun_req_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .traffic_pending (traffic_pending),
   .run_ctl_en      (run_ctl_en),
   .bus_clk_halted  (bus_clk_halted),
   .line_drive_low  (line_drive_low),
   .clk_claimed     (clk_claimed)
);

// File: tb/tb_clkrun_req_ctrl.sv
`timescale 1ns/1ps
module tb_clkrun_req_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_n_i = 1'b0;
   logic traffic_pending = 1'b0;
   logic run_ctl_en = 1'b1;
   logic bus_clk_halted = 1'b0;
   logic line_drive_low;
   logic clk_claimed;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit    q_drv[$];
   bit    q_clm[$];
   string q_tag[$];

   always #4 clk = ~clk;

   clkrun_req_ctrl dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .line_n_i        (line_n_i),
      .traffic_pending (traffic_pending),
      .run_ctl_en      (run_ctl_en),
      .bus_clk_halted  (bus_clk_halted),
      .line_drive_low  (line_drive_low),
      .clk_claimed     (clk_claimed)
   );

   task automatic step(input bit l, input bit b, input bit e, input bit s,
                       input bit exp_d, input bit exp_c, input string tag);
      @(negedge clk);
      line_n_i = l; traffic_pending = b; run_ctl_en = e; bus_clk_halted = s;
      q_drv.push_back(exp_d);
      q_clm.push_back(exp_c);
      q_tag.push_back(tag);
   endtask

   // monitor: compares after each rising edge, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_tag.size() > 0) begin
            bit ed, ec;
            string t;
            ed = q_drv.pop_front();
            ec = q_clm.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (line_drive_low !== ed || clk_claimed !== ec) begin
               errors++;
               $display("FAIL %s: drive=%b claimed=%b expected drive=%b claimed=%b",
                        t, line_drive_low, clk_claimed, ed, ec);
            end
            checks++;
            if (clk_claimed === 1'b1 && line_drive_low !== 1'b1) begin
               errors++;
               $display("FAIL R11: claimed=%b drive=%b expected drive=1", clk_claimed, line_drive_low);
            end
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (line_drive_low !== 1'b0 || clk_claimed !== 1'b0) begin
         errors++;
         $display("FAIL R1: drive=%b claimed=%b expected 0 0", line_drive_low, clk_claimed);
      end
      rst_n = 1'b1;

      repeat (3) step(0, 0, 1, 0, 0, 0, "R2");
      repeat (3) step(0, 1, 1, 0, 0, 0, "R4");
      // host stop request while busy: claim after SYNC_STAGES+1 edges
      repeat (2) step(1, 1, 1, 0, 0, 0, "R3");
      step(1, 1, 1, 0, 1, 1, "R3");
      repeat (2) step(0, 1, 1, 0, 1, 1, "R3");
      step(0, 0, 1, 0, 0, 0, "R5");
      repeat (4) step(1, 0, 1, 0, 0, 0, "R2");
      // restart request, broken confirmation, completion without traffic
      step(1, 0, 1, 1, 0, 0, "R2");
      step(1, 1, 1, 1, 1, 0, "R6");
      repeat (3) step(0, 1, 1, 1, 1, 0, "R7");
      step(0, 0, 1, 1, 1, 0, "R7");
      step(0, 0, 1, 0, 1, 0, "R7");
      step(0, 0, 1, 1, 1, 0, "R7");
      step(0, 0, 1, 0, 1, 0, "R7");
      step(0, 0, 1, 0, 0, 0, "R8");
      // restart completing into a hold
      step(0, 1, 1, 1, 1, 0, "R6");
      step(0, 1, 1, 0, 1, 0, "R7");
      step(0, 1, 1, 0, 1, 1, "R8");
      // clock halts during a hold
      step(0, 1, 1, 1, 1, 0, "R6");
      step(0, 0, 1, 0, 1, 0, "R7");
      step(0, 0, 1, 0, 0, 0, "R8");
      // feature disabled: permanent claim
      step(1, 0, 0, 0, 1, 1, "R9");
      step(1, 0, 0, 1, 1, 1, "R9");
      step(0, 1, 0, 0, 1, 1, "R9");
      step(0, 0, 0, 0, 1, 1, "R9");
      step(0, 0, 1, 0, 0, 0, "R10");
      step(0, 0, 0, 0, 1, 1, "R9");
      step(0, 1, 1, 0, 1, 1, "R10");
      step(0, 0, 1, 0, 0, 0, "R5");
      step(0, 0, 0, 0, 1, 1, "R9");
      step(0, 1, 1, 1, 1, 0, "R10");
      step(0, 1, 1, 0, 1, 0, "R7");
      step(0, 1, 1, 0, 1, 1, "R8");
      step(0, 0, 1, 0, 0, 0, "R5");

      wait (q_tag.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule